// File: doc/BRIEF.md
# Gated Edge Counter with End-of-Measurement Flag

This block measures the frequency of an input signal. It counts rising edges of that signal during a gate window of known length. A controller then reads the count, either in parallel or as a serial stream with the most significant bit first. Gate windows and settling waits are measured in milliseconds. A free-running divider turns the system clock into a 1 ms tick, and the number of clock cycles per millisecond is a parameter.

Control values are sampled on a latch strobe, which marks the end of a bus transfer. The latched run bit works as a level control. While it is 0, the count is held at zero. When it changes from 0 to 1, a measurement is armed. A settling wait comes first, and its length depends on the gate selection. The gate window follows the wait. When the window closes, a flag is raised. If status reporting is enabled, the flag pulls a shared status line low until the next bus activity.

Top module: `fcnt_gated`

## Requirements
- R1: After reset, `cnt_val` is 0, `end_low` is 0 and `rd_bit` is 0.
- R2: A latch strobe with `ctl_run`=1 starts a measurement only if the previously latched run bit was 0. A latch strobe with `ctl_run`=1 while already running leaves `cnt_val` unchanged.
- R3: A latch strobe with `ctl_run`=0 clears `cnt_val` to 0 on the next cycle. The count then stays 0 whatever `sig_in` does.
- R4: A settling wait follows the starting latch, and no edges are counted during it. The wait is 4 ms ticks for `ctl_gsel` codes 00 and 01, giving 3 to 4 ms after the latch. It is 8 ticks for codes 10 and 11, giving 7 to 8 ms.
- R5: The gate window lasts exactly 4, 8, 32 or 64 ms for `ctl_gsel` codes 00, 01, 10 and 11. The code is captured at the starting latch.
- R6: During the gate window, `cnt_val` increases by one for each rising edge of `sig_in`, to within one count of frequency times gate time. Outside the window it does not change, except when cleared.
- R7: The counter saturates at all ones and does not wrap.
- R8: While `inhibit` is 1, no edge is counted.
- R9: An end flag is set when the gate window closes and is cleared at the start of a measurement. `end_low`=1 means the status line is driven low, and it equals the flag ANDed with `end_sel`.
- R10: A cycle with `bus_active`=1 clears the end flag, so `end_low` is 0 on the following cycle.
- R11: `rd_load` copies `cnt_val` into a readout register, and `rd_bit` shows its most significant bit. Each `rd_shift` presents the next lower bit, so CNT_W shifts read out the whole count from MSB to LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the timebase source |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Signal whose edges are counted (asynchronous) |
| ctl_latch | input | 1 | One-cycle strobe that latches the control inputs |
| ctl_run | input | 1 | Run level: 0 clears the count, a 0-to-1 change starts a measurement |
| ctl_gsel | input | 2 | Gate-time select code |
| inhibit | input | 1 | Stops counting while high |
| bus_active | input | 1 | High during bus transfers; clears the end flag |
| end_sel | input | 1 | Routes the end flag to the status line |
| rd_load | input | 1 | Load the count into the readout register |
| rd_shift | input | 1 | Advance the readout by one bit |
| rd_bit | output | 1 | Serial readout bit, MSB first |
| cnt_val | output | CNT_W | Parallel count value |
| end_low | output | 1 | 1 = status line driven low (measurement ended) |

## Verification
Saturation is the hardest case to reach from the ports: a 20-bit count needs over a million edges, which is far more than a short run allows. The bench therefore drives a second instance with a narrow counter from the same stimulus. The 64 ms gate then overruns that counter while the wide instance still returns the exact count. The wait window's boundaries depend on the free-running tick phase, so the bench times each measurement from latch to status and accepts the one-millisecond spread the requirement allows.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_GATE = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  localparam int unsigned MSC_W = 7;

  function automatic logic [MSC_W-1:0] gate_ms(input logic [1:0] code);
    logic [MSC_W-1:0] r;
    case (code)
      2'b00:   r = 7'd4;
      2'b01:   r = 7'd8;
      2'b10:   r = 7'd32;
      default: r = 7'd64;
    endcase
    return r;
  endfunction

  function automatic logic [MSC_W-1:0] wait_ms(input logic [1:0] code);
    return code[1] ? 7'd8 : 7'd4;
  endfunction

endpackage

// File: rtl/fcnt_timebase.sv
module fcnt_timebase #(
  parameter int unsigned MS_CYCLES = 7200
) (
  input  logic clk,
  input  logic rst_n,
  output logic ms_tick
);
  localparam int unsigned TW = (MS_CYCLES > 1) ? $clog2(MS_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(MS_CYCLES - 1);

  logic [TW-1:0] div_q, div_d;
  logic          wrap;

  always_comb begin
    wrap  = (div_q == LAST);
    div_d = wrap ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign ms_tick = wrap;
endmodule

// File: rtl/fcnt_edge_sync.sv
module fcnt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_async,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  assign sync_d[0] = sig_async;
  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    assign sync_d[i] = sync_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/fcnt_sequencer.sv
module fcnt_sequencer
  import fcnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_latch,
  input  logic       ctl_run,
  input  logic [1:0] ctl_gsel,
  input  logic       ms_tick,
  input  logic       bus_active,
  output logic       gate_open,
  output logic       cnt_clr,
  output logic       done_flag
);
  phase_e           phase_q, phase_d;
  logic [MSC_W-1:0] msc_q, msc_d;
  logic [1:0]       sel_q, sel_d;
  logic             run_q, run_d;
  logic             flag_q, flag_d;
  logic             start, stop;

  always_comb begin
    phase_d = phase_q;
    msc_d   = msc_q;
    sel_d   = sel_q;
    run_d   = run_q;
    flag_d  = flag_q;
    cnt_clr = 1'b0;
    start   = ctl_latch & ctl_run & ~run_q;
    stop    = ctl_latch & ~ctl_run;
    if (ctl_latch) run_d = ctl_run;
    if (bus_active) flag_d = 1'b0;
    if (stop) begin
      phase_d = PH_IDLE;
      msc_d   = '0;
      flag_d  = 1'b0;
      cnt_clr = 1'b1;
    end else if (start) begin
      phase_d = PH_WAIT;
      msc_d   = '0;
      sel_d   = ctl_gsel;
      flag_d  = 1'b0;
      cnt_clr = 1'b1;
    end else if (ms_tick) begin
      case (phase_q)
        PH_WAIT: begin
          if (msc_q == wait_ms(sel_q) - 7'd1) begin
            phase_d = PH_GATE;
            msc_d   = '0;
          end else begin
            msc_d = msc_q + 7'd1;
          end
        end
        PH_GATE: begin
          if (msc_q == gate_ms(sel_q) - 7'd1) begin
            phase_d = PH_DONE;
            msc_d   = '0;
            if (!bus_active) flag_d = 1'b1;
          end else begin
            msc_d = msc_q + 7'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      msc_q   <= '0;
      sel_q   <= 2'b00;
      run_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      msc_q   <= msc_d;
      sel_q   <= sel_d;
      run_q   <= run_d;
      flag_q  <= flag_d;
    end
  end

  assign gate_open = (phase_q == PH_GATE);
  assign done_flag = flag_q;
endmodule

// File: rtl/fcnt_counter.sv
module fcnt_counter #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] val_q, val_d;
  logic         en;

  always_comb begin
    en    = clr | (inc & (val_q != TOP));
    val_d = clr ? '0 : val_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= '0;
    else if (en) val_q <= val_d;
  end

  assign value = val_q;
endmodule

// File: rtl/fcnt_readout.sv
module fcnt_readout #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] par,
  output logic         ser
);
  logic [W-1:0] sr_q, sr_d;
  logic         en;

  always_comb begin
    en   = load | shift;
    sr_d = load ? par : {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sr_q <= '0;
    else if (en) sr_q <= sr_d;
  end

  assign ser = sr_q[W-1];
endmodule

// File: rtl/fcnt_gated.sv
module fcnt_gated #(
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned MS_CYCLES   = 7200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             ctl_latch,
  input  logic             ctl_run,
  input  logic [1:0]       ctl_gsel,
  input  logic             inhibit,
  input  logic             bus_active,
  input  logic             end_sel,
  input  logic             rd_load,
  input  logic             rd_shift,
  output logic             rd_bit,
  output logic [CNT_W-1:0] cnt_val,
  output logic             end_low
);
  logic [1:0] rs_q;
  logic       rst_int_n;
  logic       ms_tick, rise, gate_open, cnt_clr, done_flag, cnt_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  fcnt_timebase #(.MS_CYCLES(MS_CYCLES)) u_tb (
    .clk(clk), .rst_n(rst_int_n), .ms_tick(ms_tick)
  );

  fcnt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .sig_async(sig_in), .rise(rise)
  );

  fcnt_sequencer u_seq (
    .clk(clk), .rst_n(rst_int_n), .ctl_latch(ctl_latch), .ctl_run(ctl_run),
    .ctl_gsel(ctl_gsel), .ms_tick(ms_tick), .bus_active(bus_active),
    .gate_open(gate_open), .cnt_clr(cnt_clr), .done_flag(done_flag)
  );

  assign cnt_inc = rise & gate_open & ~inhibit;

  fcnt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .clr(cnt_clr), .inc(cnt_inc), .value(cnt_val)
  );

  fcnt_readout #(.W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_int_n), .load(rd_load), .shift(rd_shift),
    .par(cnt_val), .ser(rd_bit)
  );

  assign end_low = done_flag & end_sel;
endmodule

// File: rtl/fcnt_gated_chk.sv
module fcnt_gated_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             ctl_latch,
  input logic             ctl_run,
  input logic             inhibit,
  input logic             bus_active,
  input logic             gate_open,
  input logic [CNT_W-1:0] cnt_val,
  input logic             end_low
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cnt_val != $past(cnt_val) && cnt_val != '0) |-> (cnt_val == $past(cnt_val) + 1'b1)); // R6

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    !gate_open |=> (cnt_val == $past(cnt_val) || cnt_val == '0)); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cnt_val == TOP) |=> (cnt_val == TOP || cnt_val == '0)); // R7

  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    inhibit |=> (cnt_val == $past(cnt_val) || cnt_val == '0)); // R8

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_latch && !ctl_run) |=> (cnt_val == '0)); // R3

  AST_BUS_OPENS: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_active |=> !end_low); // R10
endmodule

bind fcnt_gated fcnt_gated_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .ctl_latch(ctl_latch), .ctl_run(ctl_run),
  .inhibit(inhibit), .bus_active(bus_active), .gate_open(gate_open),
  .cnt_val(cnt_val), .end_low(end_low)
);

// File: tb/sim_fcnt_gated.sv
`timescale 1ns/1ps
module sim_fcnt_gated;
  localparam int M = 40;
  localparam int NARROW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_in = 1'b0;
  logic ctl_latch = 1'b0, ctl_run = 1'b0, inhibit = 1'b0, bus_active = 1'b0;
  logic end_sel = 1'b1, rd_load = 1'b0, rd_shift = 1'b0;
  logic [1:0] ctl_gsel = 2'b00;
  logic rd_bit, end_low, rd_bit1, end_low1;
  logic [19:0] cnt_val;
  logic [NARROW-1:0] cnt_val1;

  int tests = 0, fails = 0, cycles = 0, half = 0, phase_cnt = 0;

  always #4 clk = ~clk;

  fcnt_gated #(.CNT_W(20), .MS_CYCLES(M)) u0 (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .ctl_latch(ctl_latch),
    .ctl_run(ctl_run), .ctl_gsel(ctl_gsel), .inhibit(inhibit),
    .bus_active(bus_active), .end_sel(end_sel), .rd_load(rd_load),
    .rd_shift(rd_shift), .rd_bit(rd_bit), .cnt_val(cnt_val), .end_low(end_low));

  fcnt_gated #(.CNT_W(NARROW), .MS_CYCLES(M)) u1 (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .ctl_latch(ctl_latch),
    .ctl_run(ctl_run), .ctl_gsel(ctl_gsel), .inhibit(inhibit),
    .bus_active(bus_active), .end_sel(end_sel), .rd_load(rd_load),
    .rd_shift(rd_shift), .rd_bit(rd_bit1), .cnt_val(cnt_val1), .end_low(end_low1));

  // stimulus edge source: toggles every 'half' cycles when half > 0
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (half > 0) begin
      if (phase_cnt + 1 >= half) begin
        phase_cnt <= 0;
        sig_in <= ~sig_in;
      end else begin
        phase_cnt <= phase_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // bus transfer: bus_active high two cycles, then latch strobe
  task automatic xfer(input logic run, input logic [1:0] sel);
    @(negedge clk); bus_active = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_active = 1'b0; ctl_run = run; ctl_gsel = sel; ctl_latch = 1'b1;
    @(negedge clk); ctl_latch = 1'b0;
  endtask

  function automatic int gms(input logic [1:0] s);
    case (s) 2'b00: return 4; 2'b01: return 8; 2'b10: return 32; default: return 64; endcase
  endfunction

  task automatic measure(input logic [1:0] sel, input int hf, input string tag);
    int w, g, n, expc, lo, hi, snap;
    w = sel[1] ? 8 : 4;
    g = gms(sel);
    half = hf;
    xfer(1'b0, sel);
    xfer(1'b1, sel);
    n = 1;
    idle((w - 1) * M - 4); n = n + (w - 1) * M - 4;
    chk(cnt_val == 0, "R4", {tag, " no count during wait"}, cnt_val, 0);
    while (!end_low && n < (w + g) * M + 50) begin
      @(negedge clk); n = n + 1;
    end
    lo = (w - 1 + g) * M - 2;
    hi = (w + g) * M + 4;
    chk(n >= lo && n <= hi, "R5", {tag, " latch-to-end cycles"}, n, lo);
    chk(end_low == 1'b1, "R9", {tag, " end flag drives line"}, end_low, 1);
    expc = (g * M) / (2 * hf);
    chk(cnt_val >= expc - 1 && cnt_val <= expc + 1, "R6", {tag, " edge count"}, cnt_val, expc);
    snap = cnt_val;
    idle(60);
    chk(cnt_val == snap, "R6", {tag, " count frozen after gate"}, cnt_val, snap);
  endtask

  task automatic t_reset;
    idle(4);
    chk(cnt_val == 0, "R1", "count after reset", cnt_val, 0);
    chk(end_low == 1'b0, "R1", "status after reset", end_low, 0);
    chk(rd_bit == 1'b0, "R1", "serial bit after reset", rd_bit, 0);
  endtask

  task automatic t_readout;
    logic [19:0] exp_v;
    int bad;
    exp_v = cnt_val;
    bad = 0;
    @(negedge clk); rd_load = 1'b1;
    @(negedge clk); rd_load = 1'b0;
    for (int i = 19; i >= 0; i--) begin
      if (rd_bit !== exp_v[i]) bad = bad + 1;
      rd_shift = 1'b1;
      @(negedge clk); rd_shift = 1'b0;
    end
    chk(bad == 0, "R11", "MSB-first readout mismatching bits", bad, 0);
  endtask

  task automatic t_saturate;
    chk(cnt_val1 == {NARROW{1'b1}}, "R7", "narrow counter saturated", cnt_val1, (1 << NARROW) - 1);
  endtask

  task automatic t_rerun_and_bus;
    int snap;
    snap = cnt_val;
    chk(end_low == 1'b1, "R10", "flag set before bus", end_low, 1);
    @(negedge clk); bus_active = 1'b1;
    @(negedge clk); bus_active = 1'b0;
    chk(end_low == 1'b0, "R10", "bus activity opens line", end_low, 0);
    xfer(1'b1, 2'b00);
    idle(10 * M);
    chk(cnt_val == snap, "R2", "relatch with run high keeps count", cnt_val, snap);
  endtask

  task automatic t_stop;
    xfer(1'b0, 2'b00);
    chk(cnt_val == 0, "R3", "run low clears count", cnt_val, 0);
    idle(10 * M);
    chk(cnt_val == 0, "R3", "count held at zero", cnt_val, 0);
  endtask

  task automatic t_inhibit;
    half = 2;
    inhibit = 1'b1;
    xfer(1'b0, 2'b00);
    xfer(1'b1, 2'b00);
    idle(9 * M);
    chk(cnt_val == 0, "R8", "inhibit blocks counting", cnt_val, 0);
    inhibit = 1'b0;
  endtask

  task automatic t_end_sel;
    end_sel = 1'b0;
    half = 2;
    xfer(1'b0, 2'b00);
    xfer(1'b1, 2'b00);
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 9 * M; i++) begin
        @(negedge clk);
        if (end_low) seen = seen + 1;
      end
      chk(seen == 0, "R9", "line stays open with status unselected", seen, 0);
    end
    end_sel = 1'b1;
    #1;
    chk(end_low == 1'b1, "R9", "flag appears once selected", end_low, 1);
    xfer(1'b0, 2'b00);
    xfer(1'b1, 2'b01);
    chk(end_low == 1'b0, "R9", "flag cleared at start", end_low, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    measure(2'b00, 2, "gate4");
    measure(2'b01, 5, "gate8");
    measure(2'b10, 2, "gate32");
    measure(2'b11, 2, "gate64");
    t_saturate();
    t_readout();
    t_rerun_and_bus();
    t_stop();
    t_inhibit();
    t_end_sel();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule